// File: doc/BRIEF.md
# Five-Stage Pipeline Interlock Unit

This block decides, once per cycle, whether the instruction sitting in decode of an in-order fetch/decode/execute/memory/writeback pipeline can leave decode. It compares every register operand that decode reads, and its condition-code read, against what the older instructions in execute and memory will write. Operands are only needed by the end of the decode cycle. A result computed in execute can therefore be forwarded to a decode occupying the same cycle. Load data is known only at the end of the memory stage, so a consumer directly behind a load waits exactly one cycle.

The unit is purely combinational. Its stall output freezes the fetch and decode stage registers, and its bubble output tells the execute stage register to load an invalid no-op at the next edge. Per-operand bypass selects tell the decode datapath which result bus each operand comes from. Condition codes are handled as one more operand, with set flags in place of a write enable.

Top module: `pipe_interlock`

## Requirements
- R1: When a valid producer in execute with write enable set and load flag clear writes a register that a used decode source names, that source's select is 1 (execute result) and no stall is raised.
- R2: When a valid load in execute with write enable set writes a register that a used decode source names, stall_fd and bubble_ex are 1 and that source's select is 0 (register file).
- R3: When the matching producer is a load in memory and execute does not match, the select is 3 (memory-stage load data) and no stall is raised.
- R4: When the matching producer is a non-load in memory and execute does not match, the select is 2 (memory-stage ALU result).
- R5: When execute and memory both write the matching register, execute wins: select 1 if it is not a load, otherwise a stall with select 0.
- R6: Producers whose valid bit or write enable (condition-code set flag for flags) is clear are ignored: selects stay 0 and no stall is raised.
- R7: A source whose use bit is clear, or any source or flag read while id_valid is 0, never stalls and has select 0.
- R8: A condition-code read takes cc_byp 1 from a non-load flag setter in execute, and otherwise 2 or 3 from a non-load or load flag setter in memory, with execute taking priority.
- R9: A flag setter in execute that is a load stalls a decode that reads the condition codes.
- R10: Each source resolves its own producer independently. Source i uses id_src bits [i*REG_W +: REG_W] and src_byp bits [2*i +: 2].
- R11: When a load is followed directly by an instruction using the loaded register, the pipeline stalls exactly one cycle. The consumer then decodes beside the load's memory stage with select 3.
- R12: bubble_ex equals stall_fd in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid | input | 1 | Decode holds a real instruction |
| id_src_use | input | NUM_SRC | Per-source read enable, bit i for source i |
| id_src | input | NUM_SRC*REG_W | Packed source register specifiers |
| id_cc_use | input | 1 | Decode reads the condition codes |
| ex_valid | input | 1 | Execute holds a real instruction |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_dst | input | REG_W | Execute destination register |
| ex_is_load | input | 1 | Execute instruction is a memory read |
| ex_cc_set | input | 1 | Execute instruction sets condition codes |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | REG_W | Memory-stage destination register |
| mem_is_load | input | 1 | Memory-stage instruction is a memory read |
| mem_cc_set | input | 1 | Memory-stage instruction sets condition codes |
| stall_fd | output | 1 | Hold fetch and decode stage registers |
| bubble_ex | output | 1 | Load a no-op into execute at the next edge |
| src_byp | output | 2*NUM_SRC | Per-source bypass select: 0 file, 1 execute, 2 memory ALU, 3 memory load |
| cc_byp | output | 2 | Condition-code bypass select, same encoding |

## Verification
The hardest situation to reach is the one-cycle load-use stall, seen from a consumer's point of view across consecutive cycles. The held consumer must first stall beside the load in execute. In the following cycle it must see the load in memory with a bubble behind it. To get there, the bench runs a small model of the stage registers. That model advances or freezes according to the unit's own stall output while it feeds a load, a multiply of the loaded value, two adds, a compare and a conditional branch. The bench counts the stall cycles and checks the selects that each later instruction sees. A vector table covers the single-cycle priority and ignore cases.

// File: rtl/pil_pkg.sv
`timescale 1ns/1ps
package pil_pkg;
   // Bypass select encoding, shared by register operands and condition codes.
   typedef enum logic [1:0] {
      BYP_RF       = 2'd0,
      BYP_EX_ALU   = 2'd1,
      BYP_MEM_ALU  = 2'd2,
      BYP_MEM_LOAD = 2'd3
   } byp_sel_e;

   localparam int unsigned BYP_W = 2;
endpackage

// File: rtl/pil_src_match.sv
`timescale 1ns/1ps
// Resolves one operand (register or flags) against the execute and memory producers.
module pil_src_match
   import pil_pkg::*;
#(
   parameter int unsigned REG_W = 4
) (
   input  logic             rd_live,
   input  logic [REG_W-1:0] rd_reg,
   input  logic             ex_live,
   input  logic [REG_W-1:0] ex_dst,
   input  logic             ex_load,
   input  logic             mem_live,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             mem_load,
   output byp_sel_e         sel,
   output logic             hazard
);

   if (REG_W < 1) begin : g_bad_width
      $error("pil_src_match: REG_W must be at least 1");
   end

   logic ex_hit;
   logic mem_hit;

   assign ex_hit  = rd_live && ex_live  && (ex_dst  == rd_reg);
   assign mem_hit = rd_live && mem_live && (mem_dst == rd_reg);

   // The youngest producer decides; a load in execute cannot forward yet.
   always_comb begin
      sel    = BYP_RF;
      hazard = 1'b0;
      if (ex_hit) begin
         if (ex_load) begin
            hazard = 1'b1;
         end else begin
            sel = BYP_EX_ALU;
         end
      end else if (mem_hit) begin
         sel = mem_load ? BYP_MEM_LOAD : BYP_MEM_ALU;
      end
   end

   always_comb begin : chk_sel
      if (sel == BYP_EX_ALU) begin
         assert_ex_sel_live_R1: assert (ex_live && !ex_load && rd_live)
            else $error("execute bypass without a live non-load producer");
      end
      if (hazard) begin
         assert_load_hazard_R2: assert (ex_load && ex_live && sel == BYP_RF)
            else $error("hazard without a load in execute");
      end
      if (sel == BYP_MEM_LOAD) begin
         assert_mem_load_sel_R3: assert (mem_live && mem_load && rd_live)
            else $error("memory load bypass without a live load");
      end
   end

endmodule

// File: rtl/pil_stall_merge.sv
`timescale 1ns/1ps
// Merges per-operand hazards into the stage-control outputs.
module pil_stall_merge #(
   parameter int unsigned N_HAZ = 3
) (
   input  logic [N_HAZ-1:0] hazards,
   input  logic             id_valid,
   output logic             stall,
   output logic             bubble
);

   if (N_HAZ < 1) begin : g_bad_count
      $error("pil_stall_merge: N_HAZ must be at least 1");
   end

   assign stall  = |hazards;
   assign bubble = stall;

   always_comb begin : chk_stall
      if (stall) begin
         assert_stall_has_decode_R7: assert (id_valid)
            else $error("stall raised with an empty decode stage");
      end
   end

endmodule

// File: rtl/pipe_interlock.sv
`timescale 1ns/1ps
module pipe_interlock
   import pil_pkg::*;
#(
   parameter int unsigned REG_W   = 4,
   parameter int unsigned NUM_SRC = 2
) (
   input  logic                     id_valid,
   input  logic [NUM_SRC-1:0]       id_src_use,
   input  logic [NUM_SRC*REG_W-1:0] id_src,
   input  logic                     id_cc_use,
   input  logic                     ex_valid,
   input  logic                     ex_wr_en,
   input  logic [REG_W-1:0]         ex_dst,
   input  logic                     ex_is_load,
   input  logic                     ex_cc_set,
   input  logic                     mem_valid,
   input  logic                     mem_wr_en,
   input  logic [REG_W-1:0]         mem_dst,
   input  logic                     mem_is_load,
   input  logic                     mem_cc_set,
   output logic                     stall_fd,
   output logic                     bubble_ex,
   output logic [2*NUM_SRC-1:0]     src_byp,
   output logic [1:0]               cc_byp
);

   localparam int unsigned N_HAZ    = NUM_SRC + 1;
   localparam int unsigned CC_SLOT  = NUM_SRC;

   if (REG_W < 1 || REG_W > 8) begin : g_bad_reg_w
      $error("pipe_interlock: REG_W out of range 1..8");
   end
   if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_num_src
      $error("pipe_interlock: NUM_SRC out of range 1..4");
   end

   logic             ex_reg_live;
   logic             mem_reg_live;
   logic             ex_cc_live;
   logic             mem_cc_live;
   logic [N_HAZ-1:0] hazards;
   byp_sel_e         src_sel [NUM_SRC];
   byp_sel_e         cc_sel;

   assign ex_reg_live  = ex_valid  && ex_wr_en;
   assign mem_reg_live = mem_valid && mem_wr_en;
   assign ex_cc_live   = ex_valid  && ex_cc_set;
   assign mem_cc_live  = mem_valid && mem_cc_set;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic rd_live;
      assign rd_live = id_valid && id_src_use[i];

      pil_src_match #(
         .REG_W (REG_W)
      ) u_match (
         .rd_live  (rd_live),
         .rd_reg   (id_src[i*REG_W +: REG_W]),
         .ex_live  (ex_reg_live),
         .ex_dst   (ex_dst),
         .ex_load  (ex_is_load),
         .mem_live (mem_reg_live),
         .mem_dst  (mem_dst),
         .mem_load (mem_is_load),
         .sel      (src_sel[i]),
         .hazard   (hazards[i])
      );

      assign src_byp[i*BYP_W +: BYP_W] = src_sel[i];

      always_comb begin : chk_young
         if (id_valid && id_src_use[i] && ex_valid && ex_wr_en &&
             ex_dst == id_src[i*REG_W +: REG_W]) begin
            assert_younger_wins_R5: assert (src_sel[i] == BYP_EX_ALU || stall_fd)
               else $error("older producer chosen over execute");
         end
      end
   end

   // Flags behave as a single one-bit register that every setter writes.
   logic cc_rd_live;
   assign cc_rd_live = id_valid && id_cc_use;

   pil_src_match #(
      .REG_W (1)
   ) u_cc_match (
      .rd_live  (cc_rd_live),
      .rd_reg   (1'b0),
      .ex_live  (ex_cc_live),
      .ex_dst   (1'b0),
      .ex_load  (ex_is_load),
      .mem_live (mem_cc_live),
      .mem_dst  (1'b0),
      .mem_load (mem_is_load),
      .sel      (cc_sel),
      .hazard   (hazards[CC_SLOT])
   );

   assign cc_byp = cc_sel;

   pil_stall_merge #(
      .N_HAZ (N_HAZ)
   ) u_merge (
      .hazards  (hazards),
      .id_valid (id_valid),
      .stall    (stall_fd),
      .bubble   (bubble_ex)
   );

   always_comb begin : chk_cc
      if (cc_byp != 2'd0) begin
         assert_cc_needs_reader_R8: assert (id_valid && id_cc_use)
            else $error("flag bypass without a flag reader");
      end
   end

endmodule

// File: tb/pipe_interlock_tb.sv
`timescale 1ns/1ps
module pipe_interlock_tb;

   logic       clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic       id_valid, id_cc_use;
   logic [1:0] id_src_use;
   logic [7:0] id_src;
   logic       ex_valid, ex_wr_en, ex_is_load, ex_cc_set;
   logic [3:0] ex_dst;
   logic       mem_valid, mem_wr_en, mem_is_load, mem_cc_set;
   logic [3:0] mem_dst;
   logic       stall_fd, bubble_ex;
   logic [3:0] src_byp;
   logic [1:0] cc_byp;

   pipe_interlock #(.REG_W(4), .NUM_SRC(2)) u_dut (
      .id_valid(id_valid), .id_src_use(id_src_use), .id_src(id_src), .id_cc_use(id_cc_use),
      .ex_valid(ex_valid), .ex_wr_en(ex_wr_en), .ex_dst(ex_dst), .ex_is_load(ex_is_load),
      .ex_cc_set(ex_cc_set), .mem_valid(mem_valid), .mem_wr_en(mem_wr_en), .mem_dst(mem_dst),
      .mem_is_load(mem_is_load), .mem_cc_set(mem_cc_set), .stall_fd(stall_fd),
      .bubble_ex(bubble_ex), .src_byp(src_byp), .cc_byp(cc_byp)
   );

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   typedef struct packed {
      logic       idv;  logic [1:0] use_; logic [3:0] s0; logic [3:0] s1; logic ccu;
      logic       exv;  logic exw; logic [3:0] exd; logic exl; logic exc;
      logic       mv;   logic mw;  logic [3:0] md;  logic ml;  logic mc;
      logic       st;   logic [1:0] e0; logic [1:0] e1; logic [1:0] ecc;
      logic [7:0] req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      // R1: ALU in execute forwards
      '{1'b1,2'b01,4'd3,4'd0,1'b0, 1'b1,1'b1,4'd3,1'b0,1'b0, 1'b0,1'b0,4'd0,1'b0,1'b0, 1'b0,2'd1,2'd0,2'd0, 8'd1},
      // R2: load in execute stalls, source 0
      '{1'b1,2'b01,4'd3,4'd0,1'b0, 1'b1,1'b1,4'd3,1'b1,1'b0, 1'b0,1'b0,4'd0,1'b0,1'b0, 1'b1,2'd0,2'd0,2'd0, 8'd2},
      // R2: load in execute stalls, source 1
      '{1'b1,2'b10,4'd0,4'd5,1'b0, 1'b1,1'b1,4'd5,1'b1,1'b0, 1'b0,1'b0,4'd0,1'b0,1'b0, 1'b1,2'd0,2'd0,2'd0, 8'd2},
      // R3: load in memory forwards load data
      '{1'b1,2'b01,4'd3,4'd0,1'b0, 1'b0,1'b0,4'd0,1'b0,1'b0, 1'b1,1'b1,4'd3,1'b1,1'b0, 1'b0,2'd3,2'd0,2'd0, 8'd3},
      // R4: ALU in memory, both sources
      '{1'b1,2'b11,4'd3,4'd3,1'b0, 1'b0,1'b0,4'd0,1'b0,1'b0, 1'b1,1'b1,4'd3,1'b0,1'b0, 1'b0,2'd2,2'd2,2'd0, 8'd4},
      // R5: execute ALU beats memory load
      '{1'b1,2'b01,4'd3,4'd0,1'b0, 1'b1,1'b1,4'd3,1'b0,1'b0, 1'b1,1'b1,4'd3,1'b1,1'b0, 1'b0,2'd1,2'd0,2'd0, 8'd5},
      // R5: execute load beats memory ALU, stall
      '{1'b1,2'b01,4'd3,4'd0,1'b0, 1'b1,1'b1,4'd3,1'b1,1'b0, 1'b1,1'b1,4'd3,1'b0,1'b0, 1'b1,2'd0,2'd0,2'd0, 8'd5},
      // R6: write enable clear in execute, memory invalid
      '{1'b1,2'b01,4'd3,4'd0,1'b0, 1'b1,1'b0,4'd3,1'b1,1'b0, 1'b0,1'b1,4'd3,1'b0,1'b0, 1'b0,2'd0,2'd0,2'd0, 8'd6},
      // R7: use bits clear
      '{1'b1,2'b00,4'd3,4'd3,1'b0, 1'b1,1'b1,4'd3,1'b1,1'b0, 1'b1,1'b1,4'd3,1'b0,1'b0, 1'b0,2'd0,2'd0,2'd0, 8'd7},
      // R7: decode invalid
      '{1'b0,2'b11,4'd3,4'd3,1'b1, 1'b1,1'b1,4'd3,1'b1,1'b1, 1'b0,1'b0,4'd0,1'b0,1'b0, 1'b0,2'd0,2'd0,2'd0, 8'd7},
      // R8: flags from execute compare
      '{1'b1,2'b00,4'd0,4'd0,1'b1, 1'b1,1'b0,4'd0,1'b0,1'b1, 1'b0,1'b0,4'd0,1'b0,1'b0, 1'b0,2'd0,2'd0,2'd1, 8'd8},
      // R8: flags from memory ALU, execute sets none
      '{1'b1,2'b00,4'd0,4'd0,1'b1, 1'b1,1'b1,4'd2,1'b0,1'b0, 1'b1,1'b0,4'd0,1'b0,1'b1, 1'b0,2'd0,2'd0,2'd2, 8'd8},
      // R9: flag-setting load in execute stalls
      '{1'b1,2'b00,4'd0,4'd0,1'b1, 1'b1,1'b1,4'd2,1'b1,1'b1, 1'b0,1'b0,4'd0,1'b0,1'b0, 1'b1,2'd0,2'd0,2'd0, 8'd9},
      // R10: independent sources
      '{1'b1,2'b11,4'd3,4'd6,1'b0, 1'b1,1'b1,4'd3,1'b0,1'b0, 1'b1,1'b1,4'd6,1'b1,1'b0, 1'b0,2'd1,2'd3,2'd0, 8'd10},
      // R6: flag setter in execute but invalid
      '{1'b1,2'b00,4'd0,4'd0,1'b1, 1'b0,1'b0,4'd0,1'b0,1'b1, 1'b0,1'b0,4'd0,1'b0,1'b0, 1'b0,2'd0,2'd0,2'd0, 8'd6},
      // R8: flags from memory load
      '{1'b1,2'b00,4'd0,4'd0,1'b1, 1'b0,1'b0,4'd0,1'b0,1'b0, 1'b1,1'b1,4'd1,1'b1,1'b1, 1'b0,2'd0,2'd0,2'd3, 8'd8}
   };

   task automatic drive_idle();
      id_valid = 1'b0; id_src_use = 2'b00; id_src = 8'd0; id_cc_use = 1'b0;
      ex_valid = 1'b0; ex_wr_en = 1'b0; ex_dst = 4'd0; ex_is_load = 1'b0; ex_cc_set = 1'b0;
      mem_valid = 1'b0; mem_wr_en = 1'b0; mem_dst = 4'd0; mem_is_load = 1'b0; mem_cc_set = 1'b0;
   endtask

   task automatic drive_vec(input vec_t v);
      id_valid = v.idv; id_src_use = v.use_; id_src = {v.s1, v.s0}; id_cc_use = v.ccu;
      ex_valid = v.exv; ex_wr_en = v.exw; ex_dst = v.exd; ex_is_load = v.exl; ex_cc_set = v.exc;
      mem_valid = v.mv; mem_wr_en = v.mw; mem_dst = v.md; mem_is_load = v.ml; mem_cc_set = v.mc;
   endtask

   // Small program for the pipeline run: registers 0,1,6,7.
   localparam int NP = 6;
   logic [1:0] p_use [NP];
   logic [3:0] p_s0  [NP];
   logic [3:0] p_s1  [NP];
   logic [3:0] p_dst [NP];
   logic       p_wr  [NP];
   logic       p_ld  [NP];
   logic       p_ccs [NP];
   logic       p_ccu [NP];

   task automatic set_instr(input int k, input logic [1:0] u, input logic [3:0] a,
                            input logic [3:0] b, input logic [3:0] d, input logic w,
                            input logic l, input logic cs, input logic cu);
      p_use[k] = u; p_s0[k] = a; p_s1[k] = b; p_dst[k] = d;
      p_wr[k] = w; p_ld[k] = l; p_ccs[k] = cs; p_ccu[k] = cu;
   endtask

   logic d_v, e_v, m_v;
   int   d_i, e_i, m_i, f_i;

   task automatic drive_pipe();
      drive_idle();
      if (d_v) begin
         id_valid = 1'b1; id_src_use = p_use[d_i];
         id_src = {p_s1[d_i], p_s0[d_i]}; id_cc_use = p_ccu[d_i];
      end
      if (e_v) begin
         ex_valid = 1'b1; ex_wr_en = p_wr[e_i]; ex_dst = p_dst[e_i];
         ex_is_load = p_ld[e_i]; ex_cc_set = p_ccs[e_i];
      end
      if (m_v) begin
         mem_valid = 1'b1; mem_wr_en = p_wr[m_i]; mem_dst = p_dst[m_i];
         mem_is_load = p_ld[m_i]; mem_cc_set = p_ccs[m_i];
      end
   endtask

   initial begin : main
      int stalls;
      drive_idle();
      @(negedge clk);
      #2;
      // Reset/idle state: nothing in flight gives no stall, no bypass (R7)
      check("R7", "idle stall", int'(stall_fd), 0);
      check("R12", "idle bubble", int'(bubble_ex), 0);
      check("R7", "idle src_byp", int'(src_byp), 0);
      check("R7", "idle cc_byp", int'(cc_byp), 0);

      for (int k = 0; k < NV; k++) begin
         string tag;
         @(negedge clk);
         drive_vec(VECS[k]);
         #2;
         tag = $sformatf("R%0d", VECS[k].req);
         check(tag, $sformatf("vec%0d stall", k), int'(stall_fd), int'(VECS[k].st));
         check("R12", $sformatf("vec%0d bubble", k), int'(bubble_ex), int'(stall_fd));
         check(tag, $sformatf("vec%0d sel0", k), int'(src_byp[1:0]), int'(VECS[k].e0));
         check(tag, $sformatf("vec%0d sel1", k), int'(src_byp[3:2]), int'(VECS[k].e1));
         check(tag, $sformatf("vec%0d cc", k), int'(cc_byp), int'(VECS[k].ecc));
      end

      // Pipeline run for R11: load, multiply of loaded value, adds, compare, branch.
      set_instr(0, 2'b01, 4'd7, 4'd0, 4'd1, 1'b1, 1'b1, 1'b0, 1'b0);
      set_instr(1, 2'b11, 4'd1, 4'd1, 4'd1, 1'b1, 1'b0, 1'b1, 1'b0);
      set_instr(2, 2'b01, 4'd7, 4'd0, 4'd7, 1'b1, 1'b0, 1'b1, 1'b0);
      set_instr(3, 2'b11, 4'd1, 4'd0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0);
      set_instr(4, 2'b11, 4'd7, 4'd6, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0);
      set_instr(5, 2'b00, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1);
      d_v = 1'b1; d_i = 0; f_i = 1; e_v = 1'b0; e_i = 0; m_v = 1'b0; m_i = 0;
      stalls = 0;
      for (int cyc = 0; cyc < 7; cyc++) begin
         @(negedge clk);
         drive_pipe();
         #2;
         if (stall_fd) stalls++;
         case (cyc)
            1: begin
               check("R11", "cycle1 load-use stall", int'(stall_fd), 1);
               check("R2", "cycle1 sel0 while stalled", int'(src_byp[1:0]), 0);
            end
            2: begin
               check("R11", "cycle2 no stall", int'(stall_fd), 0);
               check("R11", "cycle2 sel0 load data", int'(src_byp[1:0]), 3);
               check("R11", "cycle2 sel1 load data", int'(src_byp[3:2]), 3);
            end
            4: check("R4", "cycle4 sel0 memory ALU", int'(src_byp[1:0]), 2);
            5: check("R4", "cycle5 sel0 memory ALU", int'(src_byp[1:0]), 2);
            6: check("R8", "cycle6 branch flags", int'(cc_byp), 1);
            default: ;
         endcase
         // advance the stage model
         m_v = e_v; m_i = e_i;
         if (stall_fd) begin
            e_v = 1'b0;
         end else begin
            e_v = d_v; e_i = d_i;
            if (f_i < NP) begin
               d_v = 1'b1; d_i = f_i; f_i++;
            end else begin
               d_v = 1'b0;
            end
         end
      end
      check("R11", "total stall cycles", stalls, 1);

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule